// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Transceiver with Selectable Word Length

This block moves characters over a pair of asynchronous serial lines, one outgoing and one incoming. The two directions run at the same time and do not wait on each other. A shared tick source produces one enable per third of an instruction cycle. Each direction counts those ticks against a common bit-period divisor, so the bit time is set in thirds of an instruction cycle. The word can be 7, 8 or 9 bits long. A character is framed by a low start bit, then the data least significant bit first, then a high stop bit.

The transmitter takes a word through a valid/ready handshake. Its state machine has the states `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_STOP` and `TX_STOP2`. Transitions run from idle to start when a word is accepted, from start to data at the end of the start bit, and from data to stop after the last data bit. From stop the machine goes to stop2 when continuous mode is on or a word is waiting, and back to idle otherwise. From stop2 it goes to start when a word is waiting, and back to idle otherwise. In continuous mode, words can be accepted during the stop period. Back-to-back characters are then separated by exactly two stop bits.

The receiver synchronizes the line and sees a falling edge. Its states are `RX_IDLE`, `RX_START`, `RX_DATA` and `RX_STOP`. It moves from idle to start on a falling edge. In start it checks the line at mid-bit: a high level sends it back to idle, a low level moves it to data. Data moves to stop after the last bit is sampled at mid-bit. Stop returns to idle after the stop sample. The received word, right-aligned, is presented with a one-cycle strobe and a framing-error flag.

Top module: `uart_duplex`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is high, `rx_valid` is low and `rx_err` is low.
- R2: A sent character is a low start bit, then the data bits LSB first, then a high stop bit. The number of data bits follows `len_sel`: 0 gives 7, 1 gives 8, 2 gives 9 and 3 gives 8. Only `tx_data[n-1:0]` is sent.
- R3: A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low in the cycle that follows.
- R4: With `cont_en` low, `tx_ready` is high only in idle. With `tx_valid` held high, the next start bit begins exactly (n+2)·B+1 clocks after the previous one, where B is the bit period in clocks.
- R5: With `cont_en` high, a word offered during the stop period is accepted there. Its start bit begins exactly (n+3)·B clocks after the previous start bit.
- R6: With `cont_en` high and no further word offered, `txd` stays high and `tx_ready` returns high after the second stop bit.
- R7: A received character with a high stop bit raises `rx_valid` for exactly one clock. `rx_data` then holds the n data bits right-aligned, with zeros above them, and `rx_err` is low.
- R8: A low pulse on `rxd` shorter than half a bit is rejected and produces no `rx_valid`. A following valid character is still received correctly.
- R9: A low level at the stop-bit sample sets `rx_err` together with `rx_valid`, and the data is still delivered. `rx_err` and `rx_data` change only when `rx_valid` is high.
- R10: A character can be received while one is being sent, and neither disturbs the other.
- R11: One bit lasts `baud_div` ticks. A tick occurs every `CLK_PER_TICK` clocks, which is one third of an instruction cycle. The divisor is valid from 16 to 8192, and both ends of that range give exact character lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Bit period in ticks (16 to 8192) |
| len_sel | input | 2 | Word length: 0 = 7, 1 = 8, 2 = 9, 3 = 8 bits |
| cont_en | input | 1 | Continuous transmission (two stop bits between characters) |
| tx_data | input | 9 | Word to send, right-aligned |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Transmitter can accept a word |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, idles high |
| rx_data | output | 9 | Received word, right-aligned |
| rx_valid | output | 1 | One-clock strobe for a received word |
| rx_err | output | 1 | Stop bit sampled low for the last word |

## Verification
The bench measures start-to-start spacing to the exact clock, in both single-stop and continuous modes. A design that miscounted the bit period, or dropped or duplicated a stop bit, would shift those spacings by a clock or a whole bit. Word-length corners send all-zero 7- and 8-bit words, so an extra transmitted bit would land low where the stop bit belongs. A 9-bit word with only its top bit set catches a design that truncates the MSB. On the receive side, a short low glitch would yield a spurious word in a design without the mid-bit start check. A low stop bit must set the error flag without swallowing the data, and the next clean word must clear the flag. Random full-duplex traffic, including both divisor extremes, shows whether one direction corrupts the other.

// File: rtl/uart_duplex_pkg.sv
package uart_duplex_pkg;

    localparam int WORD_W = 9;
    localparam int BITN_W = 4;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP,
        TX_STOP2
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    // Number of data bits for a word-length code.
    function automatic logic [BITN_W-1:0] word_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    word_bits = 4'd7;
            2'd2:    word_bits = 4'd9;
            default: word_bits = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/uart_tick.sv
module uart_tick #(
    parameter int CLK_PER_TICK = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_PER_TICK <= 1) begin : g_every_clock
            assign tick = 1'b1;
        end else begin : g_divided
            localparam int TW = $clog2(CLK_PER_TICK);
            localparam logic [TW-1:0] LAST = TW'(CLK_PER_TICK - 1);
            logic [TW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_duplex_pkg::*;
#(
    parameter int DIV_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [1:0]        len_sel,
    input  logic              cont_en,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    tx_state_t          state, nxt;
    logic [DIV_W-1:0]   bcnt;
    logic [BITN_W-1:0]  bitn;
    logic [WORD_W-1:0]  sh, hold;
    logic               pend;
    logic               bit_end, accept;
    logic [BITN_W-1:0]  nbits;

    assign nbits   = word_bits(len_sel);
    assign bit_end = tick && (bcnt == baud_div - ONE);
    assign accept  = tx_valid && tx_ready;

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (tx_valid) nxt = TX_START;
            TX_START: if (bit_end)  nxt = TX_DATA;
            TX_DATA:  if (bit_end && bitn == nbits - 4'd1) nxt = TX_STOP;
            TX_STOP:  if (bit_end)  nxt = (cont_en || pend) ? TX_STOP2 : TX_IDLE;
            TX_STOP2: if (bit_end)  nxt = (pend || accept) ? TX_START : TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            bcnt  <= '0;
            bitn  <= '0;
            sh    <= '0;
            hold  <= '0;
            pend  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == TX_IDLE || bit_end) bcnt <= '0;
            else if (tick)                   bcnt <= bcnt + ONE;
            if (state != TX_DATA)            bitn <= '0;
            else if (bit_end)                bitn <= bitn + 4'd1;
            if (accept) hold <= tx_data;
            if (state == TX_IDLE && accept)
                sh <= tx_data;
            else if (state == TX_STOP2 && bit_end && (pend || accept))
                sh <= pend ? hold : tx_data;
            else if (state == TX_DATA && bit_end)
                sh <= sh >> 1;
            if (state == TX_STOP2 && bit_end)    pend <= 1'b0;
            else if (accept && state != TX_IDLE) pend <= 1'b1;
        end
    end

    always_comb begin
        tx_ready = 1'b0;
        txd      = 1'b1;
        unique case (state)
            TX_IDLE:  tx_ready = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_STOP,
            TX_STOP2: tx_ready = cont_en && !pend;
            default:  tx_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_duplex_pkg::*;
#(
    parameter int DIV_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [1:0]        len_sel,
    input  logic              rxd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_err
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    rx_state_t          state, nxt;
    logic               s1, s2, s3;
    logic               line, fall;
    logic [DIV_W-1:0]   bcnt, half;
    logic [BITN_W-1:0]  bitn, nbits;
    logic [WORD_W-1:0]  sh;
    logic               mid_hit, bit_end;

    assign line    = s2;
    assign fall    = s3 && !s2;
    assign half    = baud_div >> 1;
    assign nbits   = word_bits(len_sel);
    assign mid_hit = tick && (bcnt == half - ONE);
    assign bit_end = tick && (bcnt == baud_div - ONE);

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (fall)    nxt = RX_START;
            RX_START: if (mid_hit) nxt = line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bitn == nbits - 4'd1) nxt = RX_STOP;
            RX_STOP:  if (bit_end) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            s1    <= 1'b1;
            s2    <= 1'b1;
            s3    <= 1'b1;
            bcnt  <= '0;
            bitn  <= '0;
            sh    <= '0;
        end else begin
            state <= nxt;
            s1    <= rxd;
            s2    <= s1;
            s3    <= s2;
            if (state == RX_IDLE || (state == RX_START && mid_hit) || bit_end)
                bcnt <= '0;
            else if (tick)
                bcnt <= bcnt + ONE;
            if (state != RX_DATA) bitn <= '0;
            else if (bit_end)     bitn <= bitn + 4'd1;
            if (state == RX_IDLE)                sh <= '0;
            else if (state == RX_DATA && bit_end) sh <= {line, sh[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_err   <= 1'b0;
        end else begin
            rx_valid <= (state == RX_STOP) && bit_end;
            if (state == RX_STOP && bit_end) begin
                rx_data <= sh >> (4'd9 - nbits);
                rx_err  <= !line;
            end
        end
    end
endmodule

// File: rtl/uart_duplex.sv
module uart_duplex
    import uart_duplex_pkg::*;
#(
    parameter int CLK_PER_TICK = 1,
    parameter int DIV_W        = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [1:0]        len_sel,
    input  logic              cont_en,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_err
);
    logic tick;

    uart_tick #(.CLK_PER_TICK(CLK_PER_TICK)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    uart_tx #(.DIV_W(DIV_W)) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .baud_div (baud_div),
        .len_sel  (len_sel),
        .cont_en  (cont_en),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .txd      (txd)
    );

    uart_rx #(.DIV_W(DIV_W)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .baud_div (baud_div),
        .len_sel  (len_sel),
        .rxd      (rxd),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_err   (rx_err)
    );
endmodule

// File: rtl/uart_duplex_chk.sv
module uart_duplex_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic [8:0] rx_data,
    input logic       rx_valid,
    input logic       rx_err
);
    // R1: leaving reset finds the transmitter idle
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (txd && tx_ready));

    // R2: a low line level only occurs inside a character, never while ready
    a_r2_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> !tx_ready);

    // R3: an accepted word closes the handshake for the next cycle
    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R7: the receive strobe lasts a single clock
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9: the error flag only moves with a delivered word
    a_r9_err_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_err) |-> rx_valid);

    // R9: the received word only moves with the strobe
    a_r9_data_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_valid);
endmodule

bind uart_duplex uart_duplex_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_err   (rx_err)
);

// File: tb/test_uart_duplex.sv
module test_uart_duplex;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] baud_div = 14'd16;
    logic [1:0]  len_sel = 2'd1;
    logic        cont_en = 1'b0;
    logic [8:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, txd;
    logic        rxd = 1'b1;
    logic [8:0]  rx_data;
    logic        rx_valid, rx_err;

    always #10 clk = ~clk;

    uart_duplex i_uart_duplex (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .len_sel(len_sel),
        .cont_en(cont_en), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_err(rx_err)
    );

    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;
    int     rx_cnt = 0;
    logic [8:0] rx_last = '0;
    logic       rx_last_err = 1'b0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt++;
            rx_last     = rx_data;
            rx_last_err = rx_err;
        end
    end

    function automatic int exp_len(input logic [1:0] sel);
        return (sel == 2'd0) ? 7 : (sel == 2'd2) ? 9 : 8;
    endfunction

    function automatic logic [8:0] exp_mask(input logic [1:0] sel);
        return 9'h1FF >> (9 - exp_len(sel));
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input logic [8:0] d);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic cap_tx(input int n, input int b, output logic [8:0] d,
                          output bit ok, output longint t0);
        d  = '0;
        ok = 1'b1;
        while (txd) @(negedge clk);
        t0 = cyc;
        wait_clk(b / 2);
        if (txd) ok = 1'b0;
        for (int i = 0; i < n; i++) begin
            wait_clk(b);
            d[i] = txd;
        end
        wait_clk(b);
        if (!txd) ok = 1'b0;
    endtask

    task automatic drive_rx(input logic [8:0] d, input int n, input int b, input bit stop_hi);
        @(negedge clk);
        rxd = 1'b0;
        wait_clk(b);
        for (int i = 0; i < n; i++) begin
            rxd = d[i];
            wait_clk(b);
        end
        rxd = stop_hi;
        wait_clk(b);
        rxd = 1'b1;
    endtask

    // one sent character with word check and exact length to idle
    task automatic tx_one(input string req, input logic [1:0] sel, input int b, input logic [8:0] d);
        logic [8:0] got;
        bit ok;
        longint t0;
        len_sel  = sel;
        baud_div = 14'(b);
        fork
            push_tx(d);
            cap_tx(exp_len(sel), b, got, ok, t0);
        join
        chk(req, "tx word", got, d & exp_mask(sel));
        chk(req, "tx framing", ok, 1);
        while (!tx_ready) @(negedge clk);
        chk(req, "char length", cyc - t0, (exp_len(sel) + 2) * b);
    endtask

    task automatic run_all();
        logic [8:0] g1, g2;
        bit o1, o2;
        longint t1, t2;
        int base;

        wait_clk(3);
        chk("R1", "txd", txd, 1);
        chk("R1", "tx_ready", tx_ready, 1);
        chk("R1", "rx_valid", rx_valid, 0);
        chk("R1", "rx_err", rx_err, 0);
        rst_n = 1'b1;
        wait_clk(2);

        // R2: word lengths and bit order
        tx_one("R2", 2'd1, 16, 9'h0A5);
        tx_one("R2", 2'd0, 16, 9'h000);
        tx_one("R2", 2'd1, 20, 9'h000);
        tx_one("R2", 2'd2, 16, 9'h100);
        tx_one("R2", 2'd3, 18, 9'h03C);

        // R3: handshake closes after acceptance
        len_sel = 2'd1; baud_div = 14'd16;
        fork
            begin push_tx(9'h055); chk("R3", "ready after accept", tx_ready, 0); end
            cap_tx(8, 16, g1, o1, t1);
        join
        wait_clk(32);

        // R4: single stop, back to back
        cont_en = 1'b0; len_sel = 2'd1; baud_div = 14'd16;
        fork
            begin push_tx(9'h0C3); push_tx(9'h03A); end
            begin cap_tx(8, 16, g1, o1, t1); cap_tx(8, 16, g2, o2, t2); end
        join
        chk("R4", "first word", g1, 9'h0C3);
        chk("R4", "second word", g2, 9'h03A);
        chk("R4", "start spacing", t2 - t1, (8 + 2) * 16 + 1);
        wait_clk(40);

        // R5: continuous, two stop bits then next start
        cont_en = 1'b1; len_sel = 2'd0; baud_div = 14'd20;
        fork
            begin push_tx(9'h05A); push_tx(9'h027); end
            begin cap_tx(7, 20, g1, o1, t1); cap_tx(7, 20, g2, o2, t2); end
        join
        chk("R5", "first word", g1, 9'h05A);
        chk("R5", "second word", g2, 9'h027);
        chk("R5", "start spacing", t2 - t1, (7 + 3) * 20);
        wait_clk(60);

        // R6: continuous with nothing further to send
        fork
            push_tx(9'h011);
            cap_tx(7, 20, g1, o1, t1);
        join
        wait_clk(3 * 20);
        chk("R6", "line idle", txd, 1);
        chk("R6", "ready", tx_ready, 1);
        cont_en = 1'b0;

        // R7: reception, right aligned
        len_sel = 2'd2; baud_div = 14'd16; base = rx_cnt;
        drive_rx(9'h1A5, 9, 16, 1'b1);
        wait_clk(4);
        chk("R7", "strobe count", rx_cnt, base + 1);
        chk("R7", "9-bit word", rx_last, 9'h1A5);
        chk("R7", "err", rx_last_err, 0);
        len_sel = 2'd0; base = rx_cnt;
        drive_rx(9'h07F, 7, 16, 1'b1);
        wait_clk(4);
        chk("R7", "7-bit word", rx_last, 9'h07F);
        chk("R7", "strobe count", rx_cnt, base + 1);

        // R8: glitch rejection then recovery
        len_sel = 2'd1; baud_div = 14'd32; base = rx_cnt;
        @(negedge clk); rxd = 1'b0;
        wait_clk(8);
        rxd = 1'b1;
        wait_clk(64);
        chk("R8", "no strobe after glitch", rx_cnt, base);
        drive_rx(9'h0E1, 8, 32, 1'b1);
        wait_clk(4);
        chk("R8", "word after glitch", rx_last, 9'h0E1);

        // R9: framing error keeps data, then clears
        baud_div = 14'd16; base = rx_cnt;
        drive_rx(9'h03C, 8, 16, 1'b0);
        wait_clk(4);
        chk("R9", "strobe", rx_cnt, base + 1);
        chk("R9", "err set", rx_last_err, 1);
        chk("R9", "data kept", rx_last, 9'h03C);
        wait_clk(20);
        chk("R9", "err held", rx_err, 1);
        drive_rx(9'h0C5, 8, 16, 1'b1);
        wait_clk(4);
        chk("R9", "err cleared", rx_last_err, 0);

        // R10: random full-duplex traffic
        for (int k = 0; k < 12; k++) begin
            logic [1:0] sel;
            logic [8:0] td, rd;
            int b;
            sel = 2'($urandom % 4);
            b   = 16 + int'($urandom % 40);
            td  = 9'($urandom) & exp_mask(sel);
            rd  = 9'($urandom) & exp_mask(sel);
            len_sel = sel; baud_div = 14'(b); base = rx_cnt;
            fork
                begin push_tx(td); end
                begin cap_tx(exp_len(sel), b, g1, o1, t1); end
                begin wait_clk(b / 3); drive_rx(rd, exp_len(sel), b, 1'b1); end
            join
            wait_clk(2 * b);
            chk("R10", "tx word", g1, td);
            chk("R10", "tx framing", o1, 1);
            chk("R10", "rx word", rx_last, rd);
            chk("R10", "rx count", rx_cnt, base + 1);
        end

        // R11: divisor extremes give exact character length
        tx_one("R11", 2'd1, 16, 9'h0F0);
        len_sel = 2'd0; baud_div = 14'd8192; base = rx_cnt;
        fork
            tx_one("R11", 2'd0, 8192, 9'h04B);
            drive_rx(9'h033, 7, 8192, 1'b1);
        join
        wait_clk(8);
        chk("R11", "rx word slow", rx_last, 9'h033);
        chk("R11", "rx count slow", rx_cnt, base + 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        fork
            run_all();
            begin
                repeat (195000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule